// File: doc/BRIEF.md
# Ripple adder with approximate low-order cells

This block adds two W-bit operands and a carry-in through a chain of one-bit cells. Each cell passes its carry-out to the carry-in of the next cell up. The lowest L cells may use a simplified full-adder truth table, which a mode parameter selects. The remaining W−L cells are always exact. The block serves error-tolerant datapaths such as image transforms, where a few wrong low-order bits are acceptable in return for simpler cells.

Four cell behaviours are available:

- Mode 0 keeps every cell exact.
- Mode 1 forces the carry high whenever A is set. Its sum is the inverse of that carry, except that an all-zero input gives a zero sum.
- Mode 2 keeps the exact carry and takes the sum as its inverse.
- Mode 3 takes the mode-1 carry and inverts it to form the sum.

The block is purely combinational.

Top module: `lsb_approx_adder`

## Requirements
- R1: With MODE 0, or with L = 0, the pair {cout, sum} equals the exact value a + b + cin for every input.
- R2: A mode-1 cell gives carry = A | (B & Cin). Its sum is 0 when A=B=Cin=0 and is the inverse of its carry otherwise. Against the exact cell this is one carry error (at A=1,B=0,Cin=0) and two sum errors.
- R3: A mode-2 cell gives the exact majority carry and a sum equal to the inverse of that carry. This is two sum errors (inputs 000 and 111) and no carry errors.
- R4: A mode-3 cell gives carry = A | (B & Cin) and a sum equal to the inverse of that carry. This is one carry error and three sum errors (inputs 000, 100 and 111).
- R5: Bit positions L to W−1 hold the exact sum of the upper operand fields plus the carry that leaves cell L−1, or plus cin when L = 0.
- R6: The carry-out of cell i is the carry-in of cell i+1, so a carry produced at any bit propagates upward through a run of ones.
- R7: cout is the carry-out of the most significant cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of bit W−1 |

## Verification
The bench builds four single-bit instances (W=1, L=1) with MODE 0 to 3. These expose each cell's complete eight-row truth table directly at sum and cout. A 16-bit instance with L=4 and MODE 1 is used for directed carry-ripple and overflow cases, and for random vectors compared against a bench model built from the truth tables. A 16-bit instance with L=0 and MODE 2 shows that the mode has no effect when no cell is approximate.

// File: rtl/approx_adder_pkg.sv
package approx_adder_pkg;
  localparam int unsigned FA_MODE_EXACT   = 0;
  localparam int unsigned FA_MODE_CARRY_A = 1;
  localparam int unsigned FA_MODE_SUM_INV = 2;
  localparam int unsigned FA_MODE_BOTH    = 3;
  localparam int unsigned FA_MODE_COUNT   = 4;
endpackage

// File: rtl/afa_exact_cell.sv
module afa_exact_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (a & ci) | (b & ci);
  end

  always_comb begin
    AST_EXACT_ARITH: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci))); // R1
  end
endmodule

// File: rtl/afa_approx_cell.sv
module afa_approx_cell #(
  parameter int unsigned MODE = approx_adder_pkg::FA_MODE_CARRY_A
) (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import approx_adder_pkg::*;

  logic maj;
  logic any_in;
  assign maj    = (a & b) | (a & ci) | (b & ci);
  assign any_in = a | b | ci;

  generate
    if (MODE == FA_MODE_CARRY_A) begin : g_m1
      // carry is raised by A alone; sum mirrors carry except on all-zero input
      always_comb begin
        co = a | (b & ci);
        s  = ~co & any_in;
      end
      always_comb begin
        if (a) AST_M1_A_RAISES_CARRY: assert (co); // R2
        if (!any_in) AST_M1_ZERO_IN_ZERO_OUT: assert (!s && !co); // R2
      end
    end else if (MODE == FA_MODE_SUM_INV) begin : g_m2
      always_comb begin
        co = maj;
        s  = ~maj;
      end
      always_comb begin
        AST_M2_SUM_OPPOSES_CARRY: assert (s != co); // R3
        AST_M2_CARRY_IS_EXACT: assert (co == ((2'(a) + 2'(b) + 2'(ci)) >= 2'd2)); // R3
      end
    end else if (MODE == FA_MODE_BOTH) begin : g_m3
      always_comb begin
        co = a | (b & ci);
        s  = ~co;
      end
      always_comb begin
        AST_M3_SUM_OPPOSES_CARRY: assert (s != co); // R4
        if (a) AST_M3_A_RAISES_CARRY: assert (co); // R4
      end
    end else begin : g_m0
      always_comb begin
        s  = a ^ b ^ ci;
        co = maj;
      end
      always_comb begin
        AST_M0_ARITH: assert ({co, s} == (2'(a) + 2'(b) + 2'(ci))); // R1
      end
    end
  endgenerate
endmodule

// File: rtl/lsb_approx_adder.sv
module lsb_approx_adder #(
  parameter int unsigned W    = 16,
  parameter int unsigned L    = 4,
  parameter int unsigned MODE = approx_adder_pkg::FA_MODE_CARRY_A
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  import approx_adder_pkg::*;

  localparam int unsigned LA = (L > W) ? W : L;
  localparam int unsigned HW = W - LA;

  logic [W:0] carry;
  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      if ((i < LA) && (MODE != FA_MODE_EXACT)) begin : g_apx
        afa_approx_cell #(.MODE(MODE)) u_cell (
          .a (a[i]), .b (b[i]), .ci(carry[i]),
          .s (sum[i]), .co(carry[i+1])
        );
      end else begin : g_exa
        afa_exact_cell u_cell (
          .a (a[i]), .b (b[i]), .ci(carry[i]),
          .s (sum[i]), .co(carry[i+1])
        );
      end
    end
  endgenerate

  assign cout = carry[W];

  generate
    if (HW > 0) begin : g_hi_chk
      logic [HW:0] hi_ref;
      always_comb begin
        hi_ref = {1'b0, a[W-1:LA]} + {1'b0, b[W-1:LA]} + {{HW{1'b0}}, carry[LA]};
        AST_UPPER_EXACT: assert ({cout, sum[W-1:LA]} == hi_ref); // R5
      end
    end
    if ((LA == 0) || (MODE == FA_MODE_EXACT)) begin : g_full_chk
      always_comb begin
        AST_FULL_EXACT: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin})); // R1
      end
    end
  endgenerate
endmodule

// File: tb/lsb_approx_adder_tb.sv
module lsb_approx_adder_tb;
  localparam int W = 16;
  localparam int L = 4;

  // expected {carry,sum} per mode, indexed by {a,b,cin}
  localparam logic [1:0] CELL_EXP [0:3][0:7] = '{
    '{2'b00, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 2'b10, 2'b11},
    '{2'b00, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10},
    '{2'b01, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 2'b10, 2'b10},
    '{2'b01, 2'b01, 2'b01, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum, sum_ex;
  logic         cout, cout_ex;

  logic [3:0] ca, cb, cc, cs, cco;

  lsb_approx_adder #(.W(W), .L(L), .MODE(1)) u_dut (
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

  lsb_approx_adder #(.W(W), .L(0), .MODE(2)) u_exact (
    .a(a), .b(b), .cin(cin), .sum(sum_ex), .cout(cout_ex));

  generate
    for (genvar m = 0; m < 4; m++) begin : g_cell
      lsb_approx_adder #(.W(1), .L(1), .MODE(m)) u_cell (
        .a(ca[m +: 1]), .b(cb[m +: 1]), .cin(cc[m]),
        .sum(cs[m +: 1]), .cout(cco[m]));
    end
  endgenerate

  function automatic logic [W:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                       input logic ci, input int mode, input int nl);
    logic [W:0] r;
    logic c;
    c = ci;
    r = '0;
    for (int i = 0; i < W; i++) begin
      logic [1:0] e;
      int m;
      m = (i < nl) ? mode : 0;
      e = CELL_EXP[m][{x[i], y[i], c}];
      r[i] = e[0];
      c = e[1];
    end
    r[W] = c;
    return r;
  endfunction

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci);
    @(posedge clk);
    a = x; b = y; cin = ci;
    @(negedge clk);
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0; ca = '0; cb = '0; cc = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset/zero", {cout, sum}, '0);

    // exhaustive cell truth tables, all modes
    for (int v = 0; v < 8; v++) begin
      @(posedge clk);
      ca = {4{v[2]}}; cb = {4{v[1]}}; cc = {4{v[0]}};
      @(negedge clk);
      for (int m = 0; m < 4; m++) begin
        string r;
        r = (m == 0) ? "R1 cell" : (m == 1) ? "R2 cell" : (m == 2) ? "R3 cell" : "R4 cell";
        chk(r, {{(W-1){1'b0}}, cco[m], cs[m]}, {{(W-1){1'b0}}, CELL_EXP[m][v]});
      end
    end

    // directed multi-bit cases
    drive(16'h0FF0, 16'h0010, 1'b0);
    chk("R6 ripple", {cout, sum}, {1'b0, 16'h1000});
    chk("R1 exact L0", {cout_ex, sum_ex}, {1'b0, 16'h1000});
    drive(16'hFFF0, 16'h0010, 1'b0);
    chk("R7 overflow", {cout, sum}, {1'b1, 16'h0000});
    drive(16'h0001, 16'h0000, 1'b0);
    chk("R2 low carry", {cout, sum}, {1'b0, 16'h0002});
    drive(16'h000F, 16'h000F, 1'b1);
    chk("R5 carry into upper", {cout, sum}, {1'b0, 16'h0010});
    drive(16'hFFFF, 16'hFFFF, 1'b1);
    chk("R1 exact max", {cout_ex, sum_ex}, {1'b1, 16'hFFFF});

    // random vectors
    for (int n = 0; n < 300; n++) begin
      logic [W-1:0] x, y;
      logic ci;
      x = W'($urandom); y = W'($urandom); ci = 1'($urandom);
      drive(x, y, ci);
      chk("R5 random", {cout, sum}, model(x, y, ci, 1, L));
      chk("R1 random exact", {cout_ex, sum_ex}, {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci});
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule